// File: doc/BRIEF.md
# Two-Port Memory Interface Controller

This block sits between a microcoded data path and a main memory that is addressed by word. It has two independent ports. The word port holds a 32-bit address register and a 32-bit data register and carries reads and writes. The byte port holds a program counter and an 8-bit instruction byte buffer and carries only fetches. The data path loads the registers from its result bus and asks for each memory operation with one strobe bit in the current cycle.

Read and fetch results reach the data path a fixed two cycles after the request. The memory takes the first of those cycles. The controller captures the result at the end of the second. Until then the old register contents stay visible. Requests on either port may be issued in back-to-back cycles, and each one completes in its own slot. The word address is turned into a byte address by shifting it left by two. The program counter is already a byte address and goes out unshifted.

The memory latency, the widths and the rule for the case where a data path load and a read return land on the data register in the same cycle are parameters. The defaults are a one-cycle synchronous memory, 32-bit words, 8-bit bytes and the data path load winning.

Top module: `mem_port_ctrl`

## Requirements
- R1: While reset is low and on leaving it, the address register, data register, program counter and byte buffer read zero, and no memory strobe is active while no request is made.
- R2: In a cycle with a read or write request, the word port's memory address equals the address register shifted left by two bits. Its two low bits are zero.
- R3: A read requested in cycle k leaves the data register unchanged in cycle k+1 and shows the memory word at that address from cycle k+2 on.
- R4: Reads requested in consecutive cycles k and k+1 complete in cycles k+2 and k+3, each with the word at the address register value of its own request cycle.
- R5: A write request raises the memory write strobe in the same cycle, with the address register and data register values of that cycle. A register load made in the same cycle does not alter the written address or data.
- R6: A fetch presents the program counter value unshifted as a byte address in the request cycle. The byte buffer keeps its old value in cycle k+1 and holds the returned byte from cycle k+2.
- R7: A read and a fetch requested in the same cycle both complete two cycles later, each with its own result.
- R8: When a data path load of the data register coincides with a read return, the loaded value is kept and the returned word is dropped.
- R9: A load of the address register, data register or program counter from the data path is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_ld | input | 1 | Load the address register from addr_in |
| addr_in | input | 32 | New address register value (word address) |
| data_ld | input | 1 | Load the data register from data_in |
| data_in | input | 32 | New data register value |
| pc_ld | input | 1 | Load the program counter from pc_in |
| pc_in | input | 32 | New program counter value (byte address) |
| rd_req | input | 1 | Word read request for this cycle |
| wr_req | input | 1 | Word write request for this cycle |
| fetch_req | input | 1 | Byte fetch request for this cycle |
| addr_q | output | 32 | Address register |
| data_q | output | 32 | Data register |
| pc_q | output | 32 | Program counter |
| byte_q | output | 8 | Instruction byte buffer |
| mem_rd | output | 1 | Memory word read strobe |
| mem_wr | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address for word accesses |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_rd |
| mem_fetch | output | 1 | Memory byte fetch strobe |
| mem_faddr | output | 32 | Memory byte address for fetches |
| mem_fbyte | input | 8 | Fetched byte, one cycle after mem_fetch |

## Verification
Several properties are checked on every clock. The data register and the byte buffer hold their values unless a return or a load arrives. A return is captured exactly as the memory delivered it one cycle earlier. The data path load wins over a return. Register loads appear in the next cycle. Other behaviour can only be shown by the bench's scenarios against its own memory model. That covers the left shift of the word address, the exact k+2 slot, the ordering of back-to-back reads, the fact that a write ignores loads made in its own cycle, and a read and a fetch running side by side.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

   // Which source wins when a data path load and a read return meet
   typedef enum logic {
      MERGE_LOAD_FIRST   = 1'b0,
      MERGE_RETURN_FIRST = 1'b1
   } merge_pol_e;

   // Number of address bits that select a byte inside a word
   function automatic int lane_bits(input int data_w, input int byte_w);
      return $clog2(data_w / byte_w);
   endfunction

endpackage

// File: rtl/mpc_lat_pipe.sv
module mpc_lat_pipe #(
   parameter int LAT = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   output logic done_o
);

   logic [LAT-1:0] stage_q;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("mpc_lat_pipe: LAT must be at least 1");
      end

      if (LAT == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q <= req_i;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_q <= '0;
            end else begin
               stage_q <= {stage_q[LAT-2:0], req_i};
            end
         end
      end
   endgenerate

   assign done_o = stage_q[LAT-1];

endmodule

// File: rtl/mpc_word_port.sv
module mpc_word_port
   import mpc_pkg::*;
#(
   parameter int         ADDR_W  = 32,
   parameter int         DATA_W  = 32,
   parameter int         SHIFT   = 2,
   parameter int         MEM_LAT = 1,
   parameter merge_pol_e POLICY  = MERGE_LOAD_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_ld,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              data_ld,
   input  logic [DATA_W-1:0] data_in,
   input  logic              rd_req,
   input  logic              wr_req,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);

   logic              ret;
   logic              data_en;
   logic [DATA_W-1:0] data_nx;

   generate
      if (SHIFT >= ADDR_W) begin : g_bad_shift
         $error("mpc_word_port: SHIFT must be below ADDR_W");
      end
   endgenerate

   // Tracks each read until its word is back from memory
   mpc_lat_pipe #(.LAT(MEM_LAT + 1 - 1)) u_rd_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (rd_req),
      .done_o (ret)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (addr_ld) begin
         addr_q <= addr_in;
      end
   end

   generate
      if (POLICY == MERGE_LOAD_FIRST) begin : g_load_first
         always_comb begin
            data_en = data_ld | ret;
            data_nx = data_ld ? data_in : mem_rdata;
         end

         // R8
         load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            data_ld |=> data_q == $past(data_in));
      end else begin : g_return_first
         always_comb begin
            data_en = data_ld | ret;
            data_nx = ret ? mem_rdata : data_in;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
      end else if (data_en) begin
         data_q <= data_nx;
      end
   end

   // Word address to byte address
   assign mem_addr  = addr_q << SHIFT;
   assign mem_rd    = rd_req;
   assign mem_wr    = wr_req;
   assign mem_wdata = data_q;

   // R3
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret && !data_ld) |=> $stable(data_q));

   // R3
   data_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && !data_ld) |=> data_q == $past(mem_rdata));

   // R9
   addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      addr_ld |=> addr_q == $past(addr_in));

endmodule

// File: rtl/mpc_byte_port.sv
module mpc_byte_port #(
   parameter int PC_W    = 32,
   parameter int BYTE_W  = 8,
   parameter int MEM_LAT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pc_ld,
   input  logic [PC_W-1:0]   pc_in,
   input  logic              fetch_req,
   output logic [PC_W-1:0]   pc_q,
   output logic [BYTE_W-1:0] byte_q,
   output logic              mem_fetch,
   output logic [PC_W-1:0]   mem_faddr,
   input  logic [BYTE_W-1:0] mem_fbyte
);

   logic ret;

   mpc_lat_pipe #(.LAT(MEM_LAT)) u_fetch_pipe (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (fetch_req),
      .done_o (ret)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q <= '0;
      end else if (pc_ld) begin
         pc_q <= pc_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_q <= '0;
      end else if (ret) begin
         byte_q <= mem_fbyte;
      end
   end

   // The program counter is already a byte address
   assign mem_fetch = fetch_req;
   assign mem_faddr = pc_q;

   // R6
   byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ret |=> $stable(byte_q));

   // R6
   byte_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret |=> byte_q == $past(mem_fbyte));

   // R9
   pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_ld |=> pc_q == $past(pc_in));

endmodule

// File: rtl/mem_port_ctrl.sv
module mem_port_ctrl
   import mpc_pkg::*;
#(
   parameter int         ADDR_W  = 32,
   parameter int         DATA_W  = 32,
   parameter int         BYTE_W  = 8,
   parameter int         PC_W    = 32,
   parameter int         MEM_LAT = 1,
   parameter merge_pol_e POLICY  = MERGE_LOAD_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_ld,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              data_ld,
   input  logic [DATA_W-1:0] data_in,
   input  logic              pc_ld,
   input  logic [PC_W-1:0]   pc_in,
   input  logic              rd_req,
   input  logic              wr_req,
   input  logic              fetch_req,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic [PC_W-1:0]   pc_q,
   output logic [BYTE_W-1:0] byte_q,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_fetch,
   output logic [PC_W-1:0]   mem_faddr,
   input  logic [BYTE_W-1:0] mem_fbyte
);

   localparam int WORD_SHIFT = lane_bits(DATA_W, BYTE_W);

   generate
      if (DATA_W % BYTE_W != 0) begin : g_bad_width
         $error("mem_port_ctrl: DATA_W must be a multiple of BYTE_W");
      end
      if ((1 << WORD_SHIFT) * BYTE_W != DATA_W) begin : g_bad_lanes
         $error("mem_port_ctrl: bytes per word must be a power of two");
      end
   endgenerate

   mpc_word_port #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .SHIFT   (WORD_SHIFT),
      .MEM_LAT (MEM_LAT),
      .POLICY  (POLICY)
   ) u_word (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_ld   (addr_ld),
      .addr_in   (addr_in),
      .data_ld   (data_ld),
      .data_in   (data_in),
      .rd_req    (rd_req),
      .wr_req    (wr_req),
      .addr_q    (addr_q),
      .data_q    (data_q),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   mpc_byte_port #(
      .PC_W    (PC_W),
      .BYTE_W  (BYTE_W),
      .MEM_LAT (MEM_LAT)
   ) u_byte (
      .clk       (clk),
      .rst_n     (rst_n),
      .pc_ld     (pc_ld),
      .pc_in     (pc_in),
      .fetch_req (fetch_req),
      .pc_q      (pc_q),
      .byte_q    (byte_q),
      .mem_fetch (mem_fetch),
      .mem_faddr (mem_faddr),
      .mem_fbyte (mem_fbyte)
   );

   // R5
   wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req |-> (mem_wr && mem_wdata == data_q));

endmodule

// File: tb/mem_port_ctrl_tb_top.sv
module mem_port_ctrl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        addr_ld = 1'b0, data_ld = 1'b0, pc_ld = 1'b0;
   logic [31:0] addr_in = '0, data_in = '0, pc_in = '0;
   logic        rd_req = 1'b0, wr_req = 1'b0, fetch_req = 1'b0;
   logic [31:0] addr_q, data_q, pc_q;
   logic [7:0]  byte_q;
   logic        mem_rd, mem_wr, mem_fetch;
   logic [31:0] mem_addr, mem_wdata, mem_faddr;
   logic [31:0] mem_rdata;
   logic [7:0]  mem_fbyte;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mem_port_ctrl dut_i (
      .clk(clk), .rst_n(rst_n),
      .addr_ld(addr_ld), .addr_in(addr_in),
      .data_ld(data_ld), .data_in(data_in),
      .pc_ld(pc_ld), .pc_in(pc_in),
      .rd_req(rd_req), .wr_req(wr_req), .fetch_req(fetch_req),
      .addr_q(addr_q), .data_q(data_q), .pc_q(pc_q), .byte_q(byte_q),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_fetch(mem_fetch), .mem_faddr(mem_faddr), .mem_fbyte(mem_fbyte)
   );

   // Initial content of memory word i
   function automatic logic [31:0] word_fn(input int i);
      logic [7:0] b;
      b = 8'(i);
      return {b ^ 8'h3C, 8'hA0 + b, ~b, b + 8'h11};
   endfunction

   function automatic logic [7:0] byte_fn(input int a);
      logic [31:0] w;
      w = word_fn(a >> 2);
      return 8'(w >> (8 * (a % 4)));
   endfunction

   // Synchronous memory model, one cycle latency
   logic [31:0] mem_a [256];
   initial begin
      for (int i = 0; i < 256; i++) mem_a[i] = word_fn(i);
   end
   always @(posedge clk) begin
      if (mem_rd) mem_rdata <= mem_a[mem_addr[9:2]];
      if (mem_fetch) mem_fbyte <= 8'(mem_a[mem_faddr[9:2]] >> {mem_faddr[1:0], 3'b000});
      if (mem_wr) mem_a[mem_addr[9:2]] <= mem_wdata;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic set_addr(input logic [31:0] a);
      addr_ld = 1'b1; addr_in = a;
      tick();
      addr_ld = 1'b0;
   endtask

   // Stimulus table: word addresses for the read loop
   localparam int NVEC = 8;
   localparam logic [31:0] RD_VEC [NVEC] = '{
      32'd0, 32'd1, 32'd7, 32'd42, 32'd99, 32'd128, 32'd200, 32'd255
   };

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] old_w;
      logic [7:0]  old_b;
      @(negedge clk);
      tick();
      // R1: reset state
      chk("R1 addr_q", addr_q, 32'h0);
      chk("R1 data_q", data_q, 32'h0);
      chk("R1 pc_q", pc_q, 32'h0);
      chk("R1 byte_q", {24'h0, byte_q}, 32'h0);
      chk("R1 strobes", {29'h0, mem_rd, mem_wr, mem_fetch}, 32'h0);
      rst_n = 1'b1;
      tick();
      chk("R1 after release", data_q, 32'h0);

      // R9: register loads from the data path
      set_addr(32'h15);
      chk("R9 addr_q", addr_q, 32'h15);
      data_ld = 1'b1; data_in = 32'hCAFE0001;
      tick();
      data_ld = 1'b0;
      chk("R9 data_q", data_q, 32'hCAFE0001);

      // R2, R3: table-driven reads
      for (int v = 0; v < NVEC; v++) begin
         set_addr(RD_VEC[v]);
         old_w = data_q;
         rd_req = 1'b1;
         #1;
         chk("R2 mem_addr", mem_addr, RD_VEC[v] << 2);
         tick();
         rd_req = 1'b0;
         chk("R3 k+1 old value", data_q, old_w);
         tick();
         chk("R3 k+2 new value", data_q, word_fn(int'(RD_VEC[v])));
      end

      // R4: back-to-back reads
      set_addr(32'd10);
      old_w = data_q;
      rd_req = 1'b1; addr_ld = 1'b1; addr_in = 32'd11;
      tick();
      addr_ld = 1'b0;
      chk("R4 k+1 old value", data_q, old_w);
      tick();
      rd_req = 1'b0;
      chk("R4 first read at k+2", data_q, word_fn(10));
      tick();
      chk("R4 second read at k+3", data_q, word_fn(11));

      // R5: write uses the values of the request cycle
      set_addr(32'd20);
      data_ld = 1'b1; data_in = 32'h1234ABCD;
      tick();
      wr_req = 1'b1;
      addr_ld = 1'b1; addr_in = 32'd21;
      data_ld = 1'b1; data_in = 32'h0BAD0BAD;
      #1;
      chk("R5 mem_wr", {31'h0, mem_wr}, 32'h1);
      chk("R5 write address", mem_addr, 32'd20 << 2);
      chk("R5 write data", mem_wdata, 32'h1234ABCD);
      tick();
      wr_req = 1'b0; addr_ld = 1'b0; data_ld = 1'b0;
      set_addr(32'd20);
      rd_req = 1'b1; tick(); rd_req = 1'b0; tick();
      chk("R5 written word", data_q, 32'h1234ABCD);
      set_addr(32'd21);
      rd_req = 1'b1; tick(); rd_req = 1'b0; tick();
      chk("R5 neighbour untouched", data_q, word_fn(21));

      // R6: fetch with an unshifted byte address
      pc_ld = 1'b1; pc_in = 32'd37;
      tick();
      pc_ld = 1'b0;
      chk("R9 pc_q", pc_q, 32'd37);
      old_b = byte_q;
      fetch_req = 1'b1;
      #1;
      chk("R6 fetch address", mem_faddr, 32'd37);
      tick();
      fetch_req = 1'b0;
      chk("R6 k+1 old byte", {24'h0, byte_q}, {24'h0, old_b});
      tick();
      chk("R6 k+2 new byte", {24'h0, byte_q}, {24'h0, byte_fn(37)});

      // R7: read and fetch in the same cycle
      set_addr(32'd50);
      pc_ld = 1'b1; pc_in = 32'd242;
      tick();
      pc_ld = 1'b0;
      rd_req = 1'b1; fetch_req = 1'b1;
      tick();
      rd_req = 1'b0; fetch_req = 1'b0;
      tick();
      chk("R7 read result", data_q, word_fn(50));
      chk("R7 fetch result", {24'h0, byte_q}, {24'h0, byte_fn(242)});

      // R8: data path load beats the read return
      set_addr(32'd60);
      rd_req = 1'b1;
      tick();
      rd_req = 1'b0;
      data_ld = 1'b1; data_in = 32'h5A5A0F0F;
      tick();
      data_ld = 1'b0;
      chk("R8 load kept", data_q, 32'h5A5A0F0F);
      tick();
      chk("R8 return dropped", data_q, 32'h5A5A0F0F);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule